// File: doc/BRIEF.md
# Key-Protected Real-Time-Clock Register Front End

This block is the register front end of a real-time-clock domain. Software reaches it over a simple bus: a write strobe, a read strobe, a 5-bit word address and 16-bit data. The protected settings (interrupt enables, the two retention words and the alarm/time words) are written into a shadow bank. The live copies change only at a commit. A commit needs two things: the write interface must first be opened by an ordered pair of key writes, each followed by a trigger, and then a trigger must be written while the interface is open. Each accepted trigger holds a busy flag high for a fixed number of slow-clock cycles. Software polls that flag before it issues the next trigger.

Three registers sit beside the shadow bank. The oscillator-control word has its own two-key gate. The power-control word accepts a write only when a key byte travels in the upper half of the data. The interrupt status register latches enabled events and clears itself completely when it is read. A retention check combines the two committed retention words with a synchronized raw low-power input and tells the boot code whether a full initialization is needed. The slow clock and the raw low-power input both pass through a small synchronizer.

Address map (word addresses): 0 unlock-key port (reads bit 0 = open), 1 trigger, 2 power control, 3 oscillator control, 4 interrupt status, 5 control (bit 0 = raw low-power), 8 interrupt enable, 9 retention word A, 10 retention word B, 11 to 13 alarm/time words.

Top module: `rtc_kr_top`

## Requirements
- R1: The interface opens (`unlocked` = 1, bit 0 of address 0 reads 1) only after this exact order: 0x586A written to address 0, an accepted trigger, 0x9136 written to address 0, and another accepted trigger.
- R2: Any write to address 0 that is not the next expected key sends the sequence back to its start, and the interface closes. The only exception is a write of 0x586A, which begins a new sequence. Reset also closes the interface.
- R3: A trigger is a write of 1 in bit 0 to address 1. When a trigger is accepted while the interface is open, every shadow word is copied to its live word. While the interface is closed, no live word changes. Reads of addresses 8 to 13 always return the live words.
- R4: An accepted trigger raises `busy`, which also reads as bit 6 of address 2. `busy` stays high for 8 slow-clock rising edges. A trigger written while `busy` is high is ignored.
- R5: Shadow writes made while `busy` is high do not alter the commit in progress. They are applied by the next accepted trigger.
- R6: The oscillator-control word (address 3, `osc_ctrl`) stores a value only when that value is the write that immediately follows 0x1A57 and then 0x2B68 written to the same address. Any other write order leaves the word unchanged.
- R7: A write to address 2 stores data bits 5:0 into `pwr_ctrl` only when data bits 15:8 equal 0x43. Writes with any other upper byte leave the word unchanged.
- R8: Interrupt status (address 4) latches enabled events: bit 0 for the alarm, bit 1 for the tick and bit 3 for low power. `irq` is the OR of these bits. A read of address 4 returns the bits and clears all of them.
- R9: The live enable word (address 8) gates the events: bit 0 alarm, bit 1 tick, bit 3 low power. When bit 2 (one-shot) is set, a fired alarm clears the live alarm enable bit.
- R10: `init_needed` is 0 only when live word A is 0xA357, live word B is 0x67D2 and the synchronized raw low-power input is 0. Bit 0 of address 5 reads that synchronized input.
- R11: After reset the interface is closed, `busy` is 0, the live words, `pwr_ctrl`, `osc_ctrl` and the interrupt status are 0, and `init_needed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status on address 4) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| slow_clk | input | 1 | Slow real-time clock, asynchronous |
| lp_raw | input | 1 | Raw low-power status, asynchronous |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_tick | input | 1 | Tick event pulse |
| evt_lowpwr | input | 1 | Low-power event pulse |
| unlocked | output | 1 | Write interface open |
| busy | output | 1 | Commit window active |
| pwr_ctrl | output | 6 | Stored power-control bits |
| osc_ctrl | output | 16 | Stored oscillator-control word |
| irq | output | 1 | Any interrupt status bit set |
| init_needed | output | 1 | Retained state invalid |

## Verification
The bench goes after the ordering corner cases. A key written without its trigger, a correct second key arriving after a stray write, and a trigger issued while the interface is closed must all leave the live words alone. A design that counted keys without checking their order, or that committed on every trigger, would show the written retention words at the read port too early. The bench times the busy window against the slow clock and writes a shadow word inside that window. A design that copied shadows continuously, or that ended the window early or late, would show the new value before the next trigger or measure outside the 8-period window. It also runs the one-shot alarm twice, and a design that did not clear its enable would latch the second alarm. Clear-on-read is checked by reading the status register twice.

// File: rtl/rtc_kr_pkg.sv
package rtc_kr_pkg;

  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int BANK_BASE = 8;
  localparam int PWR_W     = 6;
  localparam int BUSY_BIT  = 6;

  localparam logic [ADDR_W-1:0] A_KEY  = 5'd0;
  localparam logic [ADDR_W-1:0] A_TRIG = 5'd1;
  localparam logic [ADDR_W-1:0] A_PWR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_OSC  = 5'd3;
  localparam logic [ADDR_W-1:0] A_ISTA = 5'd4;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd5;

  localparam logic [DATA_W-1:0] UNLOCK_KEY_A = 16'h586A;
  localparam logic [DATA_W-1:0] UNLOCK_KEY_B = 16'h9136;
  localparam logic [DATA_W-1:0] OSC_KEY_A    = 16'h1A57;
  localparam logic [DATA_W-1:0] OSC_KEY_B    = 16'h2B68;
  localparam logic [7:0]        PWR_KEY_BYTE = 8'h43;
  localparam logic [DATA_W-1:0] RETAIN_A     = 16'hA357;
  localparam logic [DATA_W-1:0] RETAIN_B     = 16'h67D2;

  localparam int EV_ALARM = 0;
  localparam int EV_TICK  = 1;
  localparam int EV_ONCE  = 2;
  localparam int EV_LOWP  = 3;

  typedef enum logic [2:0] {
    U_SHUT, U_KEYA, U_TRGA, U_KEYB, U_OPEN
  } unlock_e;

  typedef enum logic [1:0] {
    O_IDLE, O_KEYA, O_ARMED
  } osc_e;

  function automatic unlock_e key_step(unlock_e cur, logic [DATA_W-1:0] d);
    if (cur == U_TRGA && d == UNLOCK_KEY_B) return U_KEYB;
    return (d == UNLOCK_KEY_A) ? U_KEYA : U_SHUT;
  endfunction

  function automatic unlock_e trig_step(unlock_e cur);
    case (cur)
      U_KEYA:  return U_TRGA;
      U_KEYB:  return U_OPEN;
      default: return cur;
    endcase
  endfunction

  function automatic logic pwr_key_ok(logic [DATA_W-1:0] d);
    return d[15:8] == PWR_KEY_BYTE;
  endfunction

  function automatic logic retained_ok(logic [DATA_W-1:0] wa,
                                       logic [DATA_W-1:0] wb, logic lp);
    return (wa == RETAIN_A) && (wb == RETAIN_B) && !lp;
  endfunction

endpackage

// File: rtl/rtc_kr_sync.sv
module rtc_kr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rtc_kr_unlock.sv
module rtc_kr_unlock
  import rtc_kr_pkg::*;
#(
  parameter int BUSY_SLOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              trig_wr,
  input  logic              slow_tick,
  output logic              unlocked,
  output logic              busy,
  output logic              trig_fire,
  output logic              commit_fire
);
  localparam int CW = $clog2(BUSY_SLOW + 1);

  unlock_e         state;
  logic [CW-1:0]   tick_cnt;

  assign trig_fire   = trig_wr && !busy;
  assign commit_fire = trig_fire && (state == U_OPEN);
  assign unlocked    = (state == U_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= U_SHUT;
    end else if (key_wr) begin
      state <= key_step(state, key_data);
    end else if (trig_fire) begin
      state <= trig_step(state);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (trig_fire) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
    end else if (busy && slow_tick) begin
      if (tick_cnt == CW'(BUSY_SLOW - 1)) begin
        busy     <= 1'b0;
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_kr_osc.sv
module rtc_kr_osc
  import rtc_kr_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_wr,
  input  logic [DATA_W-1:0] osc_data,
  output logic [DATA_W-1:0] osc_val,
  output logic              osc_store
);
  osc_e gate;

  assign osc_store = osc_wr && (gate == O_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate    <= O_IDLE;
      osc_val <= RST_VAL;
    end else if (osc_wr) begin
      case (gate)
        O_IDLE:  gate <= (osc_data == OSC_KEY_A) ? O_KEYA : O_IDLE;
        O_KEYA:  gate <= (osc_data == OSC_KEY_B) ? O_ARMED : O_IDLE;
        default: begin
          gate    <= O_IDLE;
          osc_val <= osc_data;
        end
      endcase
    end
  end
endmodule

// File: rtl/rtc_kr_irq.sv
module rtc_kr_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] en,
  input  logic       evt_alarm,
  input  logic       evt_tick,
  input  logic       evt_lowpwr,
  input  logic       sta_rd,
  output logic [3:0] sta,
  output logic       irq,
  output logic       alarm_selfclr
);
  import rtc_kr_pkg::*;

  logic       hit_al, hit_tc, hit_lp;
  logic [3:0] hits;

  assign hit_al = evt_alarm  && en[EV_ALARM];
  assign hit_tc = evt_tick   && en[EV_TICK];
  assign hit_lp = evt_lowpwr && en[EV_LOWP];
  assign hits   = {hit_lp, 1'b0, hit_tc, hit_al};

  assign alarm_selfclr = hit_al && en[EV_ONCE];
  assign irq = |sta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta <= '0;
    else        sta <= (sta_rd ? 4'b0000 : sta) | hits;
  end
endmodule

// File: rtl/rtc_kr_top.sv
module rtc_kr_top
  import rtc_kr_pkg::*;
#(
  parameter int                NUM_BANK    = 6,
  parameter int                BUSY_SLOW   = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OSC_RST     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_clk,
  input  logic              lp_raw,
  input  logic              evt_alarm,
  input  logic              evt_tick,
  input  logic              evt_lowpwr,
  output logic              unlocked,
  output logic              busy,
  output logic [PWR_W-1:0]  pwr_ctrl,
  output logic [DATA_W-1:0] osc_ctrl,
  output logic              irq,
  output logic              init_needed
);
  localparam int FLAT_W = NUM_BANK * DATA_W;

  logic [1:0]        sync_out;
  logic              slow_s, slow_d, slow_tick, lp_sync;
  logic              trig_fire, commit_fire, alarm_selfclr, osc_store;
  logic              key_wr, trig_wr, sta_rd;
  logic [3:0]        irq_sta;
  logic [DATA_W-1:0] shadow    [NUM_BANK];
  logic [DATA_W-1:0] committed [NUM_BANK];
  logic [FLAT_W-1:0] commit_flat;

  rtc_kr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({lp_raw, slow_clk}),
    .d_sync  (sync_out)
  );
  assign slow_s  = sync_out[0];
  assign lp_sync = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_d <= 1'b0;
    else        slow_d <= slow_s;
  end
  assign slow_tick = slow_s && !slow_d;

  assign key_wr  = bus_wr && (bus_addr == A_KEY);
  assign trig_wr = bus_wr && (bus_addr == A_TRIG) && bus_wdata[0];
  assign sta_rd  = bus_rd && (bus_addr == A_ISTA);

  rtc_kr_unlock #(.BUSY_SLOW(BUSY_SLOW)) u_unlock (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .key_data    (bus_wdata),
    .trig_wr     (trig_wr),
    .slow_tick   (slow_tick),
    .unlocked    (unlocked),
    .busy        (busy),
    .trig_fire   (trig_fire),
    .commit_fire (commit_fire)
  );

  rtc_kr_osc #(.RST_VAL(OSC_RST)) u_osc (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_wr    (bus_wr && (bus_addr == A_OSC)),
    .osc_data  (bus_wdata),
    .osc_val   (osc_ctrl),
    .osc_store (osc_store)
  );

  rtc_kr_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (committed[0][3:0]),
    .evt_alarm     (evt_alarm),
    .evt_tick      (evt_tick),
    .evt_lowpwr    (evt_lowpwr),
    .sta_rd        (sta_rd),
    .sta           (irq_sta),
    .irq           (irq),
    .alarm_selfclr (alarm_selfclr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_ctrl <= '0;
    else if (bus_wr && bus_addr == A_PWR && pwr_key_ok(bus_wdata))
      pwr_ctrl <= bus_wdata[PWR_W-1:0];
  end

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BANK_BASE + g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow[g] <= '0;
      else if (bus_wr && bus_addr == MY_ADDR) shadow[g] <= bus_wdata;
    end

    if (g == 0) begin : g_en_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             committed[g] <= '0;
        else if (commit_fire)   committed[g] <= shadow[g];
        else if (alarm_selfclr) committed[g][EV_ALARM] <= 1'b0;
      end
    end else begin : g_plain_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           committed[g] <= '0;
        else if (commit_fire) committed[g] <= shadow[g];
      end
    end

    assign commit_flat[g*DATA_W +: DATA_W] = committed[g];
  end

  assign init_needed = !retained_ok(committed[1], committed[2], lp_sync);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_KEY:   bus_rdata[0] = unlocked;
      A_PWR:   begin
        bus_rdata[PWR_W-1:0] = pwr_ctrl;
        bus_rdata[BUSY_BIT]  = busy;
      end
      A_OSC:   bus_rdata = osc_ctrl;
      A_ISTA:  bus_rdata[3:0] = irq_sta;
      A_CTRL:  bus_rdata[0] = lp_sync;
      default: begin
        for (int i = 0; i < NUM_BANK; i++)
          if (bus_addr == ADDR_W'(BANK_BASE + i)) bus_rdata = committed[i];
      end
    endcase
  end
endmodule

// File: rtl/rtc_kr_checker.sv
module rtc_kr_checker
  import rtc_kr_pkg::*;
#(
  parameter int NUM_BANK  = 6,
  parameter int BUSY_SLOW = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       evt_alarm,
  input logic                       evt_tick,
  input logic                       evt_lowpwr,
  input logic                       unlocked,
  input logic                       busy,
  input logic                       irq,
  input logic [PWR_W-1:0]           pwr_ctrl,
  input logic                       trig_fire,
  input logic                       commit_fire,
  input logic                       slow_tick,
  input logic                       alarm_selfclr,
  input logic [NUM_BANK*DATA_W-1:0] commit_flat
);
  localparam int TW = $clog2(BUSY_SLOW + 2);
  logic [TW-1:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ticks_seen <= '0;
    else if (trig_fire)         ticks_seen <= '0;
    else if (busy && slow_tick) ticks_seen <= ticks_seen + 1'b1;
  end

  p_open_after_trigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(trig_fire));

  p_key_write_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_KEY && unlocked) |=> !unlocked);

  p_commit_when_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> unlocked);

  p_live_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_fire && !alarm_selfclr) |=> $stable(commit_flat));

  p_busy_after_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> busy);

  p_busy_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ticks_seen < TW'(BUSY_SLOW)));

  p_busy_full_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ticks_seen == TW'(BUSY_SLOW)));

  p_pwr_keyless_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PWR && bus_wdata[15:8] != PWR_KEY_BYTE) |=> $stable(pwr_ctrl));

  p_status_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_ISTA && !evt_alarm && !evt_tick && !evt_lowpwr) |=> !irq);

  p_oneshot_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_selfclr && !commit_fire) |=> !commit_flat[EV_ALARM]);
endmodule

bind rtc_kr_top rtc_kr_checker #(.NUM_BANK(NUM_BANK), .BUSY_SLOW(BUSY_SLOW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .evt_alarm     (evt_alarm),
  .evt_tick      (evt_tick),
  .evt_lowpwr    (evt_lowpwr),
  .unlocked      (unlocked),
  .busy          (busy),
  .irq           (irq),
  .pwr_ctrl      (pwr_ctrl),
  .trig_fire     (trig_fire),
  .commit_fire   (commit_fire),
  .slow_tick     (slow_tick),
  .alarm_selfclr (alarm_selfclr),
  .commit_flat   (commit_flat)
);

// File: tb/rtc_kr_top_tb_top.sv
module rtc_kr_top_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, lp_raw = 1'b0;
  logic        evt_alarm = 1'b0, evt_tick = 1'b0, evt_lowpwr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, osc_ctrl;
  logic [5:0]  pwr_ctrl;
  logic        unlocked, busy, irq, init_needed;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always #32 slow_clk = ~slow_clk;

  rtc_kr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_clk(slow_clk), .lp_raw(lp_raw), .evt_alarm(evt_alarm),
    .evt_tick(evt_tick), .evt_lowpwr(evt_lowpwr), .unlocked(unlocked),
    .busy(busy), .pwr_ctrl(pwr_ctrl), .osc_ctrl(osc_ctrl), .irq(irq),
    .init_needed(init_needed)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic trig_wait();
    wr(5'd1, 16'h0001); wait_idle();
  endtask

  task automatic open_iface();
    wr(5'd0, 16'h586A); trig_wait(); wr(5'd0, 16'h9136); trig_wait();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) evt_alarm = 1'b1; else if (which == 1) evt_tick = 1'b1; else evt_lowpwr = 1'b1;
    @(negedge clk); evt_alarm = 1'b0; evt_tick = 1'b0; evt_lowpwr = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    rd(5'd0, v);  chk("R11 closed after reset", v, 16'h0000);
    rd(5'd2, v);  chk("R11 power word", v, 16'h0000);
    rd(5'd9, v);  chk("R11 live word A", v, 16'h0000);
    chk("R11 osc word", osc_ctrl, 16'h0000);
    chk("R11 init_needed", {15'b0, init_needed}, 16'h0001);
    chk("R11 irq/busy", {14'b0, irq, busy}, 16'h0000);
  endtask

  task automatic t_closed_no_commit();
    logic [15:0] v;
    wr(5'd9, 16'hA357); trig_wait();
    rd(5'd9, v); chk("R3 closed trigger commits nothing", v, 16'h0000);
  endtask

  task automatic t_unlock_order();
    wr(5'd0, 16'h586A); trig_wait();
    chk("R1 half sequence stays closed", {15'b0, unlocked}, 16'h0000);
    wr(5'd0, 16'h9136);
    chk("R1 second key without trigger", {15'b0, unlocked}, 16'h0000);
    trig_wait();
    chk("R1 open after full sequence", {15'b0, unlocked}, 16'h0001);
  endtask

  task automatic t_commit_retain();
    logic [15:0] v;
    wr(5'd9, 16'hA357); wr(5'd10, 16'h67D2);
    rd(5'd10, v); chk("R3 shadow not yet live", v, 16'h0000);
    trig_wait();
    rd(5'd9, v);  chk("R3 word A committed", v, 16'hA357);
    rd(5'd10, v); chk("R3 word B committed", v, 16'h67D2);
    chk("R10 valid retention", {15'b0, init_needed}, 16'h0000);
  endtask

  task automatic t_bad_key();
    wr(5'd0, 16'h1111);
    chk("R2 stray key write closes", {15'b0, unlocked}, 16'h0000);
    wr(5'd0, 16'h586A); trig_wait();
    wr(5'd0, 16'h1234); wr(5'd0, 16'h9136); trig_wait();
    chk("R2 broken sequence stays closed", {15'b0, unlocked}, 16'h0000);
    open_iface();
    chk("R2 fresh sequence opens", {15'b0, unlocked}, 16'h0001);
  endtask

  task automatic t_busy_window();
    logic [15:0] v;
    logic mid = 1'b0;
    int n = 0;
    wr(5'd11, 16'h1111);
    @(negedge clk); bus_addr = 5'd1; bus_wdata = 16'h0001; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 5'd11; bus_wdata = 16'h2222; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 5'd1; bus_wdata = 16'h0001; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 5'd2; n = 3;
    while (busy && n < 400) begin
      if (n == 30) begin #1; mid = bus_rdata[6]; end
      @(negedge clk); n++;
    end
    chk("R4 busy bit in power word", {15'b0, mid}, 16'h0001);
    chk("R4 window of 8 slow periods", {15'b0, (n >= 56 && n <= 74)}, 16'h0001);
    rd(5'd11, v); chk("R5 write during busy not in commit", v, 16'h1111);
    trig_wait();
    rd(5'd11, v); chk("R5 queued write applied by next trigger", v, 16'h2222);
  endtask

  task automatic t_osc_gate();
    wr(5'd3, 16'h0055);
    chk("R6 keyless osc write ignored", osc_ctrl, 16'h0000);
    wr(5'd3, 16'h1A57); wr(5'd3, 16'h2B68); wr(5'd3, 16'h00A5);
    chk("R6 keyed osc write stored", osc_ctrl, 16'h00A5);
    wr(5'd3, 16'h0077);
    chk("R6 gate closes after store", osc_ctrl, 16'h00A5);
    wr(5'd3, 16'h1A57); wr(5'd3, 16'h1234); wr(5'd3, 16'h0033);
    chk("R6 wrong second key", osc_ctrl, 16'h00A5);
  endtask

  task automatic t_pwr_key();
    logic [15:0] v;
    wr(5'd2, 16'h1205); chk("R7 wrong key byte ignored", {10'b0, pwr_ctrl}, 16'h0000);
    wr(5'd2, 16'h4305); chk("R7 key byte accepted", {10'b0, pwr_ctrl}, 16'h0005);
    wr(5'd2, 16'h4403); rd(5'd2, v); chk("R7 later bad key ignored", v, 16'h0005);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(5'd8, 16'h0005); trig_wait();
    pulse(0);
    chk("R8 alarm raises irq", {15'b0, irq}, 16'h0001);
    rd(5'd4, v); chk("R8 alarm status bit 0", v, 16'h0001);
    rd(5'd8, v); chk("R9 one-shot cleared alarm enable", v, 16'h0004);
    pulse(0); rd(5'd4, v); chk("R9 second alarm not latched", v, 16'h0000);
    wr(5'd8, 16'h000A); trig_wait();
    pulse(1); rd(5'd4, v); chk("R8 tick status bit 1", v, 16'h0002);
    rd(5'd4, v); chk("R8 clear on read", v, 16'h0000);
    chk("R8 irq low after clear", {15'b0, irq}, 16'h0000);
    pulse(2); pulse(0); rd(5'd4, v); chk("R9 low-power latched, alarm gated", v, 16'h0008);
  endtask

  task automatic t_lowpower_raw();
    logic [15:0] v;
    @(negedge clk); lp_raw = 1'b1; repeat (4) @(negedge clk);
    rd(5'd5, v); chk("R10 raw low-power bit", v, 16'h0001);
    chk("R10 init needed on low power", {15'b0, init_needed}, 16'h0001);
    @(negedge clk); lp_raw = 1'b0; repeat (4) @(negedge clk);
    chk("R10 valid again", {15'b0, init_needed}, 16'h0000);
  endtask

  task automatic t_reset_relock();
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset closes interface", {15'b0, unlocked}, 16'h0000);
    chk("R11 outputs after second reset", {osc_ctrl[9:0], pwr_ctrl}, 16'h0000);
    chk("R11 init_needed after second reset", {15'b0, init_needed}, 16'h0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_closed_no_commit();
    t_unlock_order();
    t_commit_retain();
    t_bad_key();
    t_busy_window();
    t_osc_gate();
    t_pwr_key();
    t_irq();
    t_lowpower_raw();
    t_reset_relock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule